// File: doc/BRIEF.md
# Write Address/Data Unscrambler

This block sits on the CPU write path of a cartridge bank-switching controller. It sits ahead of the inner register core. Software can pick one of eight scrambling modes by writing a small mode register in the $5000–$5FFF window. Each later CPU write to the $8000–$FFFF register window is translated back into the write the inner core expects. The register address is permuted, and when the translated target is the bank-select register, the low data bits are permuted as well.

Translated writes leave through a registered write-forward port, one clock after the CPU strobe. That port carries a single-cycle strobe, the real register address and the real data. Writes to the $6000–$7FFF work-RAM window leave through the same port without any change. All other CPU writes, including the mode-register write, produce no forwarded strobe.

Top module: `wr_unscrambler`

## Requirements
- R1: The mode register loads `cpu_data[2:0]` on a write whose address ANDed with $F007 equals $5007. Data bits 7:3 are ignored. A write to any other address leaves the mode unchanged.
- R2: For a write to $8000–$FFFF, the incoming index is {addr[14:13], addr[0]}. Index 0..7 stand for $8000, $8001, $A000, $A001, $C000, $C001, $E000, $E001. The forwarded address is $8000 with real-index bits 2:1 on address bits 14:13 and real-index bit 0 on address bit 0. All other incoming address bits are ignored.
- R3: Real index per incoming index 0..7 is 3,2,0,4,1,5,6,7 in mode 1. In mode 3 it is 5,0,1,2,3,7,6,4. In mode 4 it is 3,1,0,5,2,4,6,7.
- R4: In modes 0, 2, 5, 6 and 7 the real index equals the incoming index.
- R5: When the real index is 0, the forwarded data keeps bits 7:6 and forces bits 5:3 to zero. Bits 2:0 come from a lookup on incoming bits 2:0 (values 0..7). The lookup is 0,2,6,1,7,3,4,5 in mode 1. It is 0,5,4,1,7,2,6,3 in mode 2, 0,6,3,7,5,2,4,1 in mode 3, and 0,2,5,3,6,1,7,4 in mode 4. For example, mode 1 with $02 written to $A000 forwards $06 to $8000.
- R6: When the real index is not 0, the forwarded data equals the CPU data.
- R7: In modes 0, 5, 6 and 7 the bits 2:0 lookup is identity. Bits 5:3 are still cleared when the real index is 0, so $FF written to $8000 in mode 0 forwards $C7.
- R8: `fwd_we` is high in exactly the cycle after each qualifying CPU write cycle, one cycle per write cycle. The translation uses the mode in force during that CPU write cycle, so a mode write followed immediately by a register write affects that register write.
- R9: A write to $6000–$7FFF is forwarded with address and data unchanged.
- R10: A write below $6000 produces no forwarded strobe. This includes the mode-register write and other $5xxx addresses.
- R11: Synchronous reset clears `fwd_we`, `fwd_addr`, `fwd_data` and sets the mode to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| fwd_we | output | 1 | Forwarded write strobe to the inner core |
| fwd_addr | output | 16 | Real register or RAM address |
| fwd_data | output | 8 | Real write data |

## Verification
The bench builds the block with its default widths: a 16-bit address, an 8-bit data bus and a 3-bit mode. These defaults put all eight modes and all eight register indices within reach. The bench sweeps every mode against every index with every value of the low three data bits, while noise sits on the ignored address and data bits. This reaches every entry of both permutation tables, plus the R7 bit-clearing in the identity modes. Back-to-back writes and mode changes directly before or after a register write exercise the per-write mode capture of R8.

// File: rtl/unscr_pkg.sv
package unscr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;
    localparam int IDX_W  = 3;
    localparam int NMODES = 1 << MODE_W;
    localparam int NIDX   = 1 << IDX_W;
    localparam int ROW_W  = NIDX * IDX_W;

    localparam logic [ADDR_W-1:0] MODE_MASK  = 16'hF007;
    localparam logic [ADDR_W-1:0] MODE_MATCH = 16'h5007;
    localparam logic [ADDR_W-1:0] RAM_LO     = 16'h6000;
    localparam logic [ADDR_W-1:0] ROM_LO     = 16'h8000;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ROW_W-1:0]  row_t;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_MODE = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_ROM  = 2'd3
    } region_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fwd_s;

    // Rows are packed with entry 0 in the least significant slot.
    localparam row_t ROW_IDENT = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};

    // Register index permutation rows.
    localparam row_t AROW_M1 = {3'd7, 3'd6, 3'd5, 3'd1, 3'd4, 3'd0, 3'd2, 3'd3};
    localparam row_t AROW_M3 = {3'd4, 3'd6, 3'd7, 3'd3, 3'd2, 3'd1, 3'd0, 3'd5};
    localparam row_t AROW_M4 = {3'd7, 3'd6, 3'd4, 3'd2, 3'd5, 3'd0, 3'd1, 3'd3};

    // Bank-select low data bit permutation rows.
    localparam row_t DROW_M1 = {3'd5, 3'd4, 3'd3, 3'd7, 3'd1, 3'd6, 3'd2, 3'd0};
    localparam row_t DROW_M2 = {3'd3, 3'd6, 3'd2, 3'd7, 3'd1, 3'd4, 3'd5, 3'd0};
    localparam row_t DROW_M3 = {3'd1, 3'd4, 3'd2, 3'd5, 3'd7, 3'd3, 3'd6, 3'd0};
    localparam row_t DROW_M4 = {3'd4, 3'd7, 3'd1, 3'd6, 3'd3, 3'd5, 3'd2, 3'd0};

    function automatic row_t addr_row(input int m);
        case (m)
            1:       return AROW_M1;
            3:       return AROW_M3;
            4:       return AROW_M4;
            default: return ROW_IDENT;
        endcase
    endfunction

    function automatic row_t data_row(input int m);
        case (m)
            1:       return DROW_M1;
            2:       return DROW_M2;
            3:       return DROW_M3;
            4:       return DROW_M4;
            default: return ROW_IDENT;
        endcase
    endfunction

    function automatic idx_t row_pick(input row_t row, input idx_t i);
        return row[i*IDX_W +: IDX_W];
    endfunction

    function automatic idx_t idx_of_addr(input logic [ADDR_W-1:0] a);
        return {a[14:13], a[0]};
    endfunction

    function automatic logic [ADDR_W-1:0] addr_of_idx(input idx_t i);
        logic [ADDR_W-1:0] a;
        a        = ROM_LO;
        a[14:13] = i[2:1];
        a[0]     = i[0];
        return a;
    endfunction

endpackage

// File: rtl/unscr_region_dec.sv
module unscr_region_dec
    import unscr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if ((addr & MODE_MASK) == MODE_MATCH) begin
            region = RGN_MODE;
        end else if (addr >= ROM_LO) begin
            region = RGN_ROM;
        end else if (addr >= RAM_LO) begin
            region = RGN_RAM;
        end else begin
            region = RGN_NONE;
        end
    end
endmodule

// File: rtl/unscr_mode_reg.sv
module unscr_mode_reg
    import unscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (load) begin
            mode <= wdata[MODE_W-1:0];
        end
    end

    // R1: a load takes the low data bits, otherwise the mode holds.
    assert_mode_load_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> mode == $past(wdata[MODE_W-1:0]));
    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode));
    // R11: reset returns mode 0.
    assert_mode_reset_R11: assert property (@(posedge clk)
        rst |=> mode == '0);
endmodule

// File: rtl/unscr_addr_map.sv
module unscr_addr_map
    import unscr_pkg::*;
(
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr_in,
    output idx_t              real_idx,
    output logic [ADDR_W-1:0] real_addr
);
    idx_t cand [NMODES];
    idx_t in_idx;

    assign in_idx = idx_of_addr(addr_in);

    for (genvar g = 0; g < NMODES; g++) begin : g_mode_row
        localparam row_t ROW = addr_row(g);
        assign cand[g] = row_pick(ROW, in_idx);
    end

    assign real_idx  = cand[mode];
    assign real_addr = addr_of_idx(real_idx);
endmodule

// File: rtl/unscr_data_map.sv
module unscr_data_map
    import unscr_pkg::*;
(
    input  mode_t             mode,
    input  idx_t              real_idx,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);
    idx_t cand [NMODES];

    for (genvar g = 0; g < NMODES; g++) begin : g_mode_row
        localparam row_t ROW = data_row(g);
        assign cand[g] = row_pick(ROW, data_in[IDX_W-1:0]);
    end

    always_comb begin
        data_out = data_in;
        if (real_idx == '0) begin
            data_out                 = '0;
            data_out[DATA_W-1:6]     = data_in[DATA_W-1:6];
            data_out[IDX_W-1:0]      = cand[mode];
        end
    end
endmodule

// File: rtl/wr_unscrambler.sv
module wr_unscrambler
    import unscr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    output logic        fwd_we,
    output logic [15:0] fwd_addr,
    output logic [7:0]  fwd_data
);
    region_e           region;
    mode_t             mode;
    idx_t              real_idx;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_data;
    fwd_s              nxt;
    fwd_s              cur;

    unscr_region_dec u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    unscr_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .load  (cpu_we && region == RGN_MODE),
        .wdata (cpu_data),
        .mode  (mode)
    );

    unscr_addr_map u_amap (
        .mode      (mode),
        .addr_in   (cpu_addr),
        .real_idx  (real_idx),
        .real_addr (rom_addr)
    );

    unscr_data_map u_dmap (
        .mode     (mode),
        .real_idx (real_idx),
        .data_in  (cpu_data),
        .data_out (rom_data)
    );

    always_comb begin
        nxt = cur;
        nxt.we = 1'b0;
        if (cpu_we) begin
            case (region)
                RGN_ROM: begin
                    nxt.we   = 1'b1;
                    nxt.addr = rom_addr;
                    nxt.data = rom_data;
                end
                RGN_RAM: begin
                    nxt.we   = 1'b1;
                    nxt.addr = cpu_addr;
                    nxt.data = cpu_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign fwd_we   = cur.we;
    assign fwd_addr = cur.addr;
    assign fwd_data = cur.data;

    // R8: every write at or above $6000 yields a strobe one cycle later.
    assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr >= 16'h6000) |=> fwd_we);
    // R10: nothing below $6000 (or no write at all) yields a strobe.
    assert_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && cpu_addr >= 16'h6000) |=> !fwd_we);
    // R9: work-RAM window is forwarded untouched.
    assert_ram_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr >= 16'h6000 && cpu_addr < 16'h8000)
        |=> (fwd_addr == $past(cpu_addr) && fwd_data == $past(cpu_data)));
    // R2: register writes land on one of the eight canonical addresses.
    assert_rom_form_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15]) |=> (fwd_addr[15] && fwd_addr[12:1] == '0));
    // R6: data is untouched unless the target is the bank-select register.
    assert_data_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15])
        |=> (fwd_addr == 16'h8000 || fwd_data == $past(cpu_data)));
    // R5: bank-select data keeps bits 7:6 and clears bits 5:3.
    assert_data_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15])
        |=> (fwd_addr != 16'h8000 ||
             (fwd_data[5:3] == 3'b000 && fwd_data[7:6] == $past(cpu_data[7:6]))));
    // R11: reset clears the forward port.
    assert_port_reset_R11: assert property (@(posedge clk)
        rst |=> (!fwd_we && fwd_addr == '0 && fwd_data == '0));
endmodule

// File: tb/wr_unscrambler_tb.sv
module wr_unscrambler_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int        due;
        bit        fwd;
        bit [15:0] addr;
        bit [7:0]  data;
        string     tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        fwd_we;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data;

    int    n_checks = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    m_mode = 0;
    item_t sb[$];

    wr_unscrambler u_dut (
        .clk      (clk),
        .rst      (rst),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .fwd_we   (fwd_we),
        .fwd_addr (fwd_addr),
        .fwd_data (fwd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int amap(int m, int i);
        int t1[8] = '{3, 2, 0, 4, 1, 5, 6, 7};
        int t3[8] = '{5, 0, 1, 2, 3, 7, 6, 4};
        int t4[8] = '{3, 1, 0, 5, 2, 4, 6, 7};
        case (m)
            1: return t1[i];
            3: return t3[i];
            4: return t4[i];
            default: return i;
        endcase
    endfunction

    function automatic int dmap(int m, int v);
        int t1[8] = '{0, 2, 6, 1, 7, 3, 4, 5};
        int t2[8] = '{0, 5, 4, 1, 7, 2, 6, 3};
        int t3[8] = '{0, 6, 3, 7, 5, 2, 4, 1};
        int t4[8] = '{0, 2, 5, 3, 6, 1, 7, 4};
        case (m)
            1: return t1[v];
            2: return t2[v];
            3: return t3[v];
            4: return t4[v];
            default: return v;
        endcase
    endfunction

    task automatic check(bit ok, string tag, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // Driver: drive one write cycle and queue the expected forward.
    task automatic wr(bit [15:0] a, bit [7:0] d, string tag = "");
        item_t it;
        int i, ri;
        it.due = cyc + 1;
        it.fwd = 1'b0;
        it.addr = '0;
        it.data = '0;
        it.tag = tag;
        if ((a & 16'hF007) == 16'h5007) begin
            if (tag == "") it.tag = "R10";
        end else if (a >= 16'h8000) begin
            i  = {a[14:13], a[0]};
            ri = amap(m_mode, i);
            it.fwd  = 1'b1;
            it.addr = 16'h8000 | (16'((ri >> 1) & 3) << 13) | 16'(ri & 1);
            if (ri == 0) it.data = {d[7:6], 3'b000, 3'(dmap(m_mode, d[2:0]))};
            else         it.data = d;
            if (tag == "") begin
                if (ri == 0) it.tag = (m_mode >= 1 && m_mode <= 4) ? "R5" : "R7";
                else         it.tag = (m_mode == 1 || m_mode == 3 || m_mode == 4) ? "R3 R6" : "R4 R6";
            end
        end else if (a >= 16'h6000) begin
            it.fwd = 1'b1; it.addr = a; it.data = d;
            if (tag == "") it.tag = "R9";
        end else begin
            if (tag == "") it.tag = "R10";
        end
        sb.push_back(it);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
        if ((a & 16'hF007) == 16'h5007) m_mode = d[2:0];
        @(negedge clk);
    endtask

    task automatic idle(string tag = "R8");
        item_t it;
        it.due = cyc + 1; it.fwd = 1'b0; it.addr = '0; it.data = '0; it.tag = tag;
        sb.push_back(it);
        cpu_we = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare the port against the queue head when it falls due.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.fwd)
                    check(fwd_we === 1'b1 && fwd_addr === it.addr && fwd_data === it.data, it.tag,
                          $sformatf("we=%b %h/%h", fwd_we, fwd_addr, fwd_data),
                          $sformatf("we=1 %h/%h", it.addr, it.data));
                else
                    check(fwd_we === 1'b0, it.tag,
                          $sformatf("we=%b", fwd_we), "we=0");
            end else if (!rst && fwd_we !== 1'b0) begin
                check(1'b0, "R10", $sformatf("unexpected we=%b", fwd_we), "we=0");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", "finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state of the forward port.
        check(fwd_we === 1'b0 && fwd_addr === 16'h0 && fwd_data === 8'h0, "R11",
              $sformatf("%b %h %h", fwd_we, fwd_addr, fwd_data), "0 0000 00");
        // R11 R7: mode 0 after reset; bits 5:3 cleared on bank select.
        wr(16'h8000, 8'hFF, "R11 R7");
        idle();
        // R5: the worked example, mode 1 $02 at $A000 -> $06 at $8000.
        wr(16'h5007, 8'h01, "R1");
        wr(16'hA000, 8'h02, "R5");
        // R8: mode switch right before and after register writes.
        wr(16'h8000, 8'h11, "R8 R3");
        wr(16'h5007, 8'h03, "R1");
        wr(16'h8000, 8'h22, "R8 R3");
        // R1: non-decoded $5xxx writes leave the mode alone.
        wr(16'h5006, 8'h01, "R10");
        wr(16'h5000, 8'h04, "R10");
        wr(16'h0123, 8'h55, "R10");
        wr(16'hC001, 8'h07, "R1 R3");
        idle();
        // R9: RAM window pass-through.
        wr(16'h6000, 8'hA5);
        wr(16'h7FFF, 8'h3C);
        wr(16'h6A5B, 8'h81);
        idle();
        // R2 R3 R4 R5 R7: full sweep, with noise on ignored bits.
        for (int m = 0; m < 8; m++) begin
            wr(16'h5FF7 - 16'(m << 8), 8'(8'hA8 | m), "R1");
            for (int i = 0; i < 8; i++) begin
                for (int k = 0; k < 8; k++) begin
                    bit [15:0] a;
                    a = 16'h8000 | (16'((i >> 1) & 3) << 13) | 16'(i & 1)
                        | (16'((k * 16'h0123) + (m * 16'h0456)) & 16'h1FFE);
                    wr(a, 8'(k | ((k * 53 + m * 29) & 8'hF8)));
                end
            end
            idle();
        end
        idle();
        idle();
        check(sb.size() == 0, "R8", $sformatf("pending=%0d", sb.size()), "pending=0");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule